// File: doc/BRIEF.md
# Frame-Synchronous Transfer Interrupt Unit

This block raises processor interrupts at fixed positions inside a repeating serial bus frame and checks that the processor answers each one in time. One enable asks for an interrupt when a frame begins. A second enable asks for one at the frame midpoint. Both sources drive one shared synchronous interrupt line. Each source has its own pending flag. The processor clears a flag with a one-cycle completion strobe for that source.

Each source has a deadline tied to a frame position. An interrupt raised at frame start must be completed before the midpoint. An interrupt raised at mid-frame must be completed before the next frame start. If a deadline passes while a flag is still pending, the flag is dropped and a sticky overflow status is raised. The processor clears the overflow status with a read-acknowledge strobe. A bit counter, reset by frame sync and advanced by a bit tick, finds the midpoint. Register bus decoding lies outside this block.

Top module: `fsx_irq_unit`

## Requirements
- R1: After a synchronous reset, pend_start, pend_mid, sync_irq and ovf_irq are 0, and the bit position is 0.
- R2: When frame_sync is 1 and en_start is 1 at a clock edge, pend_start is 1 after that edge.
- R3: The bit position is set to 0 by frame_sync. Otherwise it advances by one on each bit_tick and wraps from FRAME_LEN-1 to 0. A mid event is a bit_tick without frame_sync that moves the position from FRAME_LEN/2-1 to FRAME_LEN/2. When en_mid is 1, a mid event sets pend_mid after that edge.
- R4: sync_irq is 1 exactly when pend_start or pend_mid is 1.
- R5: ack_start clears pend_start at the next edge. When nothing is pending it has no effect. A new start event in the same cycle wins over the acknowledge.
- R6: ack_mid clears pend_mid at the next edge. When nothing is pending it has no effect. A new mid event in the same cycle wins over the acknowledge.
- R7: If pend_start is still 1 at a mid event or at a frame_sync, and ack_start is 0 in that cycle, then ovf_irq is 1 after that edge and the old start interrupt is dropped. An acknowledge in the deadline cycle counts as in time.
- R8: If pend_mid is still 1 at a frame_sync, and ack_mid is 0 in that cycle, then ovf_irq is 1 after that edge and pend_mid is 0. An acknowledge in the deadline cycle counts as in time.
- R9: ovf_irq stays 1 until a cycle with ovf_clear. A miss in that same cycle keeps it at 1.
- R10: A source whose enable is 0 never sets its pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame start strobe |
| bit_tick | input | 1 | Bit position advance strobe |
| en_start | input | 1 | Enable the frame-start interrupt |
| en_mid | input | 1 | Enable the mid-frame interrupt |
| ack_start | input | 1 | Completion strobe for the frame-start interrupt |
| ack_mid | input | 1 | Completion strobe for the mid-frame interrupt |
| ovf_clear | input | 1 | Read acknowledge that clears the overflow status |
| pend_start | output | 1 | Frame-start interrupt pending |
| pend_mid | output | 1 | Mid-frame interrupt pending |
| sync_irq | output | 1 | Synchronous interrupt status |
| ovf_irq | output | 1 | Sticky overflow status |

## Verification
If the bit position is wrong, the mid event comes on the wrong tick. pend_mid then rises, or a start deadline fires, on a different cycle than the reference model expects. Within half a frame of ticks this shows up as a mismatch on pend_mid or ovf_irq. A wrong pending flag or overflow bit is visible one clock after the strobe that should have changed it. The bench compares every output with a behavioural model on every clock, so the first wrong cycle is the one reported.

// File: rtl/fsx_pkg.sv
package fsx_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic [0:0] {
        SRC_START = 1'b0,
        SRC_MID   = 1'b1
    } src_e;

    // Per-source control for one cycle
    typedef struct packed {
        logic enable;
        logic event_hit;
        logic deadline;
        logic ack;
    } src_ctl_t;

    // Next state of one source
    typedef struct packed {
        logic pending;
        logic miss;
    } src_stat_t;

    function automatic src_stat_t src_next(input logic pending, input src_ctl_t c);
        src_stat_t r;
        r.miss    = pending && c.deadline && !c.ack;
        r.pending = pending;
        if (c.ack || c.deadline)
            r.pending = 1'b0;
        if (c.enable && c.event_hit)
            r.pending = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/fsx_frame_pos.sv
module fsx_frame_pos #(
    parameter int FRAME_LEN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    input  logic bit_tick,
    output logic start_evt,
    output logic mid_evt
);
    localparam int CNT_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
    localparam int HALF  = FRAME_LEN / 2;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] PRE_MID  = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] MID_POS  = CNT_W'(HALF);

    logic [CNT_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (frame_sync)
            pos_q <= '0;
        else if (bit_tick)
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end

    always_comb begin
        start_evt = frame_sync;
        mid_evt   = bit_tick && !frame_sync && (pos_q == PRE_MID);
    end

    // R3: position stays inside the frame
    assert_pos_range_R3: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    // R3: a mid event lands the position on the midpoint
    assert_mid_lands_R3: assert property (@(posedge clk) disable iff (rst)
        mid_evt |=> pos_q == MID_POS);

    // R3: frame sync returns the position to zero
    assert_sync_zero_R3: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> pos_q == '0);

endmodule

// File: rtl/fsx_src_track.sv
module fsx_src_track
    import fsx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_ctl_t ctl,
    output logic     pending,
    output logic     miss
);
    src_stat_t nxt;

    always_comb nxt = src_next(pending, ctl);

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else
            pending <= nxt.pending;
    end

    assign miss = nxt.miss;

    // R5 R6: an acknowledge with no new event clears the flag
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.ack && !(ctl.enable && ctl.event_hit)) |=> !pending);

    // R10: the flag only rises on an enabled event
    assert_rise_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        !(ctl.enable && ctl.event_hit) |=> !$rose(pending));

endmodule

// File: rtl/fsx_ovf_flag.sv
module fsx_ovf_flag
    import fsx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] miss_vec,
    input  logic               clear,
    output logic               ovf
);
    always_ff @(posedge clk) begin
        if (rst)
            ovf <= 1'b0;
        else
            ovf <= (ovf && !clear) || (|miss_vec);
    end

    // R9: sticky until cleared
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clear) |=> ovf);

    // R9: a miss always leaves the flag set
    assert_miss_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (|miss_vec) |=> ovf);

endmodule

// File: rtl/fsx_irq_unit.sv
module fsx_irq_unit
    import fsx_pkg::*;
#(
    parameter int FRAME_LEN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    input  logic bit_tick,
    input  logic en_start,
    input  logic en_mid,
    input  logic ack_start,
    input  logic ack_mid,
    input  logic ovf_clear,
    output logic pend_start,
    output logic pend_mid,
    output logic sync_irq,
    output logic ovf_irq
);
    logic start_evt;
    logic mid_evt;

    src_ctl_t           ctl   [NUM_SRC];
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] miss_vec;

    fsx_frame_pos #(.FRAME_LEN(FRAME_LEN)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .bit_tick   (bit_tick),
        .start_evt  (start_evt),
        .mid_evt    (mid_evt)
    );

    // Start source: raised at frame start, due by midpoint (or an early new frame)
    always_comb begin
        ctl[SRC_START].enable    = en_start;
        ctl[SRC_START].event_hit = start_evt;
        ctl[SRC_START].deadline  = mid_evt || start_evt;
        ctl[SRC_START].ack       = ack_start;
        ctl[SRC_MID].enable      = en_mid;
        ctl[SRC_MID].event_hit   = mid_evt;
        ctl[SRC_MID].deadline    = start_evt;
        ctl[SRC_MID].ack         = ack_mid;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        fsx_src_track u_trk (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[s]),
            .pending (pend_vec[s]),
            .miss    (miss_vec[s])
        );
    end

    fsx_ovf_flag u_ovf (
        .clk      (clk),
        .rst      (rst),
        .miss_vec (miss_vec),
        .clear    (ovf_clear),
        .ovf      (ovf_irq)
    );

    assign pend_start = pend_vec[SRC_START];
    assign pend_mid   = pend_vec[SRC_MID];
    assign sync_irq   = |pend_vec;

    // R7: unacknowledged start interrupt at the midpoint overflows
    assert_start_deadline_R7: assert property (@(posedge clk) disable iff (rst)
        (pend_start && mid_evt && !ack_start) |=> (ovf_irq && !pend_start));

    // R8: unacknowledged mid interrupt at the next frame start overflows
    assert_mid_deadline_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_mid && frame_sync && !ack_mid) |=> (ovf_irq && !pend_mid));

    // R2: enabled frame start raises the start flag
    assert_start_raise_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && en_start) |=> pend_start);

    // R4: interrupt line follows the pending flags
    assert_line_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_irq) |-> (!pend_start && !pend_mid));

endmodule

// File: tb/fsx_irq_unit_test.sv
module fsx_irq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int FL   = 8;
    localparam int HALF = FL / 2;

    logic clk = 1'b0;
    logic rst, frame_sync, bit_tick, en_start, en_mid, ack_start, ack_mid, ovf_clear;
    logic pend_start, pend_mid, sync_irq, ovf_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_pos = 0;
    bit m_ps = 0, m_pm = 0, m_ov = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsx_irq_unit #(.FRAME_LEN(FL)) uut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .bit_tick(bit_tick),
        .en_start(en_start), .en_mid(en_mid), .ack_start(ack_start), .ack_mid(ack_mid),
        .ovf_clear(ovf_clear), .pend_start(pend_start), .pend_mid(pend_mid),
        .sync_irq(sync_irq), .ovf_irq(ovf_irq)
    );

    always @(posedge clk) begin
        bit md, miss_s, miss_m;
        if (rst) begin
            m_pos = 0; m_ps = 0; m_pm = 0; m_ov = 0;
        end else begin
            md = bit_tick && !frame_sync && (m_pos == HALF - 1);
            miss_s = m_ps && (md || frame_sync) && !ack_start;
            miss_m = m_pm && frame_sync && !ack_mid;
            if (ack_start || md || frame_sync) m_ps = 0;
            if (frame_sync && en_start) m_ps = 1;
            if (ack_mid || frame_sync) m_pm = 0;
            if (md && en_mid) m_pm = 1;
            m_ov = (m_ov && !ovf_clear) || miss_s || miss_m;
            if (frame_sync) m_pos = 0;
            else if (bit_tick) m_pos = (m_pos == FL - 1) ? 0 : m_pos + 1;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 R5 R7 pend_start", pend_start, m_ps);
        chk("R3 R6 R8 pend_mid", pend_mid, m_pm);
        chk("R4 sync_irq", sync_irq, m_ps | m_pm);
        chk("R7 R8 R9 ovf_irq", ovf_irq, m_ov);
    endtask

    task automatic step(input bit fs, input bit tk, input bit as, input bit am, input bit oc);
        frame_sync = fs; bit_tick = tk; ack_start = as; ack_mid = am; ovf_clear = oc;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; frame_sync = 0; bit_tick = 0; en_start = 0; en_mid = 0;
        ack_start = 0; ack_mid = 0; ovf_clear = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pend_start", pend_start, 1'b0);
        chk("R1 pend_mid", pend_mid, 1'b0);
        chk("R1 sync_irq", sync_irq, 1'b0);
        chk("R1 ovf_irq", ovf_irq, 1'b0);

        // R10 disabled sources stay quiet over a full frame
        step(1, 0, 0, 0, 0);
        for (int i = 0; i < FL; i++) step(0, 1, 0, 0, 0);
        chk("R10 pend_start", pend_start, 1'b0);
        chk("R10 pend_mid", pend_mid, 1'b0);

        en_start = 1; en_mid = 1;
        // R2 and R4
        step(1, 0, 0, 0, 0);
        chk("R2 pend_start", pend_start, 1'b1);
        chk("R4 sync_irq", sync_irq, 1'b1);
        // R5 ack clears
        step(0, 0, 1, 0, 0);
        chk("R5 pend_start", pend_start, 1'b0);
        // R5 ack with nothing pending has no effect
        step(0, 0, 1, 0, 0);
        chk("R5 idle ack", pend_start, 1'b0);
        // R3 midpoint after HALF ticks
        for (int i = 0; i < HALF - 1; i++) step(0, 1, 0, 0, 0);
        chk("R3 pend_mid early", pend_mid, 1'b0);
        step(0, 1, 0, 0, 0);
        chk("R3 pend_mid", pend_mid, 1'b1);
        // R6 ack clears
        step(0, 0, 0, 1, 0);
        chk("R6 pend_mid", pend_mid, 1'b0);
        chk("R7 no ovf", ovf_irq, 1'b0);

        // R7 missed start deadline
        step(1, 0, 0, 0, 0);
        for (int i = 0; i < HALF; i++) step(0, 1, 0, 0, 0);
        chk("R7 ovf_irq", ovf_irq, 1'b1);
        chk("R7 pend_start dropped", pend_start, 1'b0);
        // R9 sticky, then cleared
        step(0, 0, 0, 1, 0);
        chk("R9 sticky", ovf_irq, 1'b1);
        step(0, 0, 0, 0, 1);
        chk("R9 cleared", ovf_irq, 1'b0);

        // R8 missed mid deadline, acked start in its deadline cycle
        step(1, 0, 0, 0, 0);
        for (int i = 0; i < HALF - 1; i++) step(0, 1, 0, 0, 0);
        step(0, 1, 1, 0, 0);
        chk("R7 ack in deadline cycle", ovf_irq, 1'b0);
        chk("R8 mid pending", pend_mid, 1'b1);
        step(1, 0, 0, 0, 0);
        chk("R8 ovf_irq", ovf_irq, 1'b1);
        chk("R8 pend_mid dropped", pend_mid, 1'b0);
        // R5 new start wins over ack in same cycle; R9 clear
        step(1, 0, 1, 0, 1);
        chk("R5 set wins", pend_start, 1'b1);
        chk("R9 clear", ovf_irq, 1'b0);

        // random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 50) == 0) en_start = $urandom % 2;
            if (($urandom % 50) == 0) en_mid = $urandom % 2;
            step(($urandom % 14) == 0, ($urandom % 3) != 0, ($urandom % 5) == 0,
                 ($urandom % 5) == 0, ($urandom % 9) == 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule